// File: doc/BRIEF.md
# Two-Lane Unfolded Three-Tap FIR Filter

This block is a three-tap finite impulse response filter whose single-rate loop has been unfolded so that every clock cycle accepts a whole group of consecutive input samples, one per lane, and returns the matching group of filtered samples. With the default of two lanes, lane 0 carries the even-indexed sample x(2k) and lane 1 carries the odd-indexed sample x(2k+1) of the same cycle. The filter computes y(n) = b0·x(n) + b1·x(n-1) + b2·x(n-2). A parameter selects a three-lane build with the same arithmetic.

Each unfolded delay is J-slow. A history register on a lane holds the sample that arrived on that lane one active cycle earlier, which is J sample positions back in the serial stream. Each tap of each lane reads either the current input of another lane or a history register. The source lane is (m − t) mod J and the source stage is the number of J-slow registers that the tap edge crosses. The coefficients are static parameters. All products and sums keep full precision, and the result goes through one output register.

Top module: `unf_fir`

## Requirements
- R1: While rst_n is low, out_valid is 0 and every bit of out_samp is 0.
- R2: out_valid equals in_valid of the previous clock cycle, so the latency is exactly one register stage.
- R3: With two lanes, lane 0 of out_samp (bits ACC_W-1:0) equals b0·x(2k) + b1·x(2k-1) + b2·x(2k-2), one cycle after in_samp lane 0 (bits DATA_W-1:0) carried x(2k).
- R4: With two lanes, lane 1 of out_samp (bits 2·ACC_W-1:ACC_W) equals b0·x(2k+1) + b1·x(2k) + b2·x(2k-1), where x(2k+1) is in_samp lane 1 (bits 2·DATA_W-1:DATA_W).
- R5: The history registers advance only on cycles with in_valid high. Cycles with in_valid low do not change later results, whatever in_samp holds.
- R6: After reset, every earlier sample counts as zero. The first group of outputs uses only the samples delivered since reset.
- R7: Samples and coefficients are 16-bit two's complement. Outputs are 34-bit two's complement and exact, with no wrap, even for full-scale samples and coefficients.
- R8: When in_valid is low, out_samp keeps its previous value in the next cycle.
- R9: With LANES = 3, lane m of out_samp equals y(3k+m) of the same serial filter, where lane m of in_samp carried x(3k+m).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the sample group on in_samp |
| in_samp | input | LANES·DATA_W | Lane m at bits [m·DATA_W +: DATA_W], holding sample x(J·k+m) |
| out_valid | output | 1 | Qualifies the result group on out_samp |
| out_samp | output | LANES·ACC_W | Lane m at bits [m·ACC_W +: ACC_W], holding y(J·k+m) |

## Verification
Each result group is due exactly one cycle after its sample group: the group is driven on a falling edge, captured at the next rising edge, and compared with a serial reference at the falling edge that follows. On every cycle the bench also checks the previous cycle's valid bit (R2). On an idle cycle it checks that the held output is unchanged (R8). Idle cycles with random data are placed at random among the valid cycles, so any leak from an idle cycle into the history registers shows up one cycle later as a wrong lane value (R5). The two-lane and three-lane builds run the same 600-sample stream. The stream opens with alternating full-scale values, which check exactness at the 34-bit width.

// File: rtl/unf_fir_pkg.sv
package unf_fir_pkg;

  // Lane that supplies tap t of output lane m in a J-unfolded filter.
  function automatic int src_lane(input int m, input int t, input int j);
    return (((m - t) % j) + j) % j;
  endfunction

  // Number of J-slow history stages crossed by that tap edge.
  function automatic int src_stage(input int m, input int t, input int j);
    return (t - m + src_lane(m, t, j)) / j;
  endfunction

  // History depth needed per lane to reach the oldest tap.
  function automatic int hist_depth(input int taps, input int j);
    return (taps - 1 + j - 1) / j;
  endfunction

endpackage

// File: rtl/unf_fir_hist.sv
module unf_fir_hist #(
  parameter int LANES  = 2,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv,
  input  logic [LANES*DATA_W-1:0]           cur,
  output logic [(DEPTH+1)*LANES*DATA_W-1:0] taps,
  output logic [DEPTH*LANES*DATA_W-1:0]     state
);
  localparam int SW = LANES * DATA_W;

  logic [DEPTH*SW-1:0] hist_q;
  logic [DEPTH*SW-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (adv) begin
      hist_d[SW-1:0] = cur;
      for (int s = 1; s < DEPTH; s++) begin
        hist_d[s*SW +: SW] = hist_q[(s-1)*SW +: SW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign taps  = {hist_q, cur};
  assign state = hist_q;
endmodule

// File: rtl/unf_fir_lane_mac.sv
module unf_fir_lane_mac
  import unf_fir_pkg::*;
#(
  parameter int                    LANE   = 0,
  parameter int                    LANES  = 2,
  parameter int                    TAPS   = 3,
  parameter int                    DATA_W = 16,
  parameter int                    COEF_W = 16,
  parameter int                    ACC_W  = 34,
  parameter int                    DEPTH  = 1,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic [(DEPTH+1)*LANES*DATA_W-1:0] taps,
  output logic signed [ACC_W-1:0]           acc
);
  localparam int PW = DATA_W + COEF_W;

  logic signed [ACC_W-1:0] term [TAPS];

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam int SL  = src_lane(LANE, t, LANES);
    localparam int ST  = src_stage(LANE, t, LANES);
    localparam int OFS = (ST * LANES + SL) * DATA_W;

    logic signed [DATA_W-1:0] smp;
    logic signed [COEF_W-1:0] cf;
    logic signed [PW-1:0]     prod;

    assign smp     = taps[OFS +: DATA_W];
    assign cf      = COEFS[t*COEF_W +: COEF_W];
    assign prod    = smp * cf;
    assign term[t] = {{(ACC_W-PW){prod[PW-1]}}, prod};
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) begin
      acc = acc + term[t];
    end
  end
endmodule

// File: rtl/unf_fir_out_stage.sv
module unf_fir_out_stage #(
  parameter int W = 68
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_q;
  logic         vld_q;

  always_comb begin
    q_d = q_q;
    if (ld) begin
      q_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      q_q   <= q_d;
      vld_q <= ld;
    end
  end

  assign q   = q_q;
  assign vld = vld_q;
endmodule

// File: rtl/unf_fir.sv
module unf_fir
  import unf_fir_pkg::*;
#(
  parameter int                    LANES  = 2,
  parameter int                    TAPS   = 3,
  parameter int                    DATA_W = 16,
  parameter int                    COEF_W = 16,
  parameter int                    ACC_W  = DATA_W + COEF_W + $clog2(TAPS),
  parameter logic [TAPS*COEF_W-1:0] COEFS = {16'sd1024, -16'sd2048, 16'sd4096}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*DATA_W-1:0] in_samp,
  output logic                    out_valid,
  output logic [LANES*ACC_W-1:0]  out_samp
);
  localparam int DEPTH = hist_depth(TAPS, LANES);

  logic [(DEPTH+1)*LANES*DATA_W-1:0] tap_bus;
  logic [DEPTH*LANES*DATA_W-1:0]     hist_state;
  logic [LANES*ACC_W-1:0]            sum_bus;

  unf_fir_hist #(
    .LANES (LANES),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) hist_i (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (in_valid),
    .cur  (in_samp),
    .taps (tap_bus),
    .state(hist_state)
  );

  for (genvar m = 0; m < LANES; m++) begin : g_lane
    logic signed [ACC_W-1:0] lane_acc;

    unf_fir_lane_mac #(
      .LANE  (m),
      .LANES (LANES),
      .TAPS  (TAPS),
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .ACC_W (ACC_W),
      .DEPTH (DEPTH),
      .COEFS (COEFS)
    ) mac_i (
      .taps(tap_bus),
      .acc (lane_acc)
    );

    assign sum_bus[m*ACC_W +: ACC_W] = lane_acc;
  end

  unf_fir_out_stage #(
    .W(LANES*ACC_W)
  ) out_i (
    .clk  (clk),
    .rst_n(rst_n),
    .ld   (in_valid),
    .d    (sum_bus),
    .q    (out_samp),
    .vld  (out_valid)
  );
endmodule

// File: rtl/unf_fir_chk.sv
module unf_fir_chk #(
  parameter int OW = 68,
  parameter int HW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_samp,
  input logic [HW-1:0] hist
);
  // R1: outputs are cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (out_valid == 1'b0 && out_samp == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  // R2: valid follows input valid by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R5: history frozen on idle cycles
  a_r5_hist_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(hist));

  // R8: output held on idle cycles
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_samp));
endmodule

bind unf_fir unf_fir_chk #(
  .OW(LANES*ACC_W),
  .HW(DEPTH*LANES*DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_samp (out_samp),
  .hist     (hist_state)
);

// File: tb/unf_fir_tb_top.sv
`timescale 1ns/1ps
module unf_fir_tb_top;
  localparam int DW = 16;
  localparam int AW = 34;
  localparam int N  = 600;
  localparam logic [47:0] CF = {16'h8EB8, 16'h7FFF, 16'h8000};

  int bc [3] = '{-32768, 32767, -29000};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic            v2, v3;
  logic [2*DW-1:0] x2;
  logic [3*DW-1:0] x3;
  logic            o2v, o3v;
  logic [2*AW-1:0] o2;
  logic [3*AW-1:0] o3;

  unf_fir #(.LANES(2), .COEFS(CF)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_samp(x2),
    .out_valid(o2v), .out_samp(o2));

  unf_fir #(.LANES(3), .COEFS(CF)) dut3_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v3), .in_samp(x3),
    .out_valid(o3v), .out_samp(o3));

  int xs [N];
  int tests = 0;
  int fails = 0;

  function automatic longint refy(input int n);
    longint a = 0;
    for (int t = 0; t < 3; t++) begin
      if (n - t >= 0) a += longint'(bc[t]) * longint'(xs[n-t]);
    end
    return a;
  endfunction

  function automatic longint lane_out(input int j, input int l);
    if (j == 2) return longint'($signed(o2[l*AW +: AW]));
    return longint'($signed(o3[l*AW +: AW]));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int j);
    int     p = 0;
    bit     done = 0;
    bit     gap = 0;
    bit     exp_v = 0;
    longint e [3] = '{0, 0, 0};
    string  tg [3] = '{"R8", "R8", "R8"};
    forever begin
      @(negedge clk);
      chk("R2", longint'(j == 2 ? o2v : o3v), longint'(exp_v));
      for (int l = 0; l < j; l++) chk(tg[l], lane_out(j, l), e[l]);
      if (done) break;
      if (p < N && (p < 12 || ($urandom % 4) != 0)) begin
        for (int l = 0; l < j; l++) begin
          if (j == 2) x2[l*DW +: DW] = xs[p+l][DW-1:0];
          else        x3[l*DW +: DW] = xs[p+l][DW-1:0];
          e[l] = refy(p + l);
          if (j == 3)        tg[l] = "R9";
          else if (p + l < 2) tg[l] = "R6";
          else if (p < 12)   tg[l] = "R7";
          else if (gap)      tg[l] = "R5";
          else               tg[l] = (l == 0) ? "R3" : "R4";
        end
        if (j == 2) v2 = 1'b1; else v3 = 1'b1;
        exp_v = 1;
        gap = 0;
        p += j;
      end else begin
        if (j == 2) begin v2 = 1'b0; x2 = {$urandom, $urandom}; end
        else        begin v3 = 1'b0; x3 = {$urandom, $urandom}; end
        exp_v = 0;
        for (int l = 0; l < 3; l++) tg[l] = "R8";
        if (p >= N) done = 1; else gap = 1;
      end
    end
    v2 = 1'b0;
    v3 = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      if (i < 12) xs[i] = (i % 2 == 0) ? 32767 : -32768;
      else        xs[i] = int'($signed(16'($urandom)));
    end
    rst_n = 1'b0;
    v2 = 1'b0; v3 = 1'b0; x2 = '1; x3 = '1;
    repeat (3) begin
      @(negedge clk);
      chk("R1", longint'(o2v), 0);
      chk("R1", longint'(o2 != '0), 0);
      chk("R1", longint'(o3v), 0);
      chk("R1", longint'(o3 != '0), 0);
    end
    rst_n = 1'b1;
    run(2);
    run(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule